// File: doc/BRIEF.md
# Ten-bit serializer with internal wrap

This block turns a stream of pre-encoded 10-bit code groups into a serial bit stream. A code group is presented on the parallel input and captured into a holding register on each rising edge of the byte clock. A bit clock running at exactly ten times the byte clock moves the captured group into a shift register once per word, at a fixed bit-counter phase. The block then sends the group out one bit per bit-clock period, least significant bit first, with consecutive words following each other with no gap.

A wrap control chooses where the serial stream goes. With wrap low, the stream drives the line output and the loopback output rests at 1. With wrap high, the stream drives only the loopback output, which feeds a receiver on the same chip, and the line output is held at a constant 1. Both serial outputs come from registers clocked by the bit clock. The encoding, the clock multiplication and the analog driver are outside this block.

Top module: `ser_tx_wrap`

## Requirements
- R1: The parallel input is sampled only at the rising byte-clock edge. Changes to the input between byte edges do not change the bits that are sent.
- R2: Each captured word produces exactly ten serial bits, one per bit-clock period. Consecutive words are sent back to back, and the internal bit counter wraps from 9 to 0.
- R3: Within a word, bit 0 goes out first and bit 9 goes out last. With wrap low, the line output carries these bits.
- R4: While wrap is high, the loopback output carries the serial stream.
- R5: While wrap is high, the line output is a static 1.
- R6: While wrap is low, the loopback output is a static 1.
- R7: A word captured at byte edge E shows its bit 0 on the serial output after bit edge E + LOAD_PHASE + 1. With the default LOAD_PHASE of 3, that is four bit periods after capture. Before the first word arrives, the output is 1.
- R8: While the synchronous reset rst is high, line_out and loop_out are both 1.
- R9: Asserting rst in the middle of a word drives both outputs back to 1 at the next bit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_byte | input | 1 | Byte clock. Its rising edge captures din. |
| clk_bit | input | 1 | Bit clock at ten times the byte clock, with its rising edges aligned to the byte edges. |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks. |
| din | input | 10 | Pre-encoded code group. Bit 0 is sent first. |
| wrap_en | input | 1 | 1 sends the stream to the loopback output and holds the line output at 1. |
| line_out | output | 1 | Serial line output, registered on clk_bit. |
| loop_out | output | 1 | Serial loopback output toward the receiver, registered on clk_bit. |

## Verification
The hardest condition to reach from the ports is a precise alignment: the first bit-clock edge after reset must also be a byte edge, because that alignment fixes the load phase and therefore the latency. The stimulus reaches it by waiting for a byte edge while reset is still high, letting nine more bit edges pass, and dropping reset half a bit period before the next byte edge. From that point every output bit can be predicted by counting edges. The bench also corrupts din right after each capture to show that only the edge value counts. It switches wrap on word boundaries, and it reasserts reset while a zero word is in flight, so that the return to 1 is visible at the outputs.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int unsigned DEF_WORD_W     = 10;
  localparam int unsigned DEF_LOAD_PHASE = 3;

  typedef enum logic {
    PATH_LINE = 1'b0,
    PATH_LOOP = 1'b1
  } path_e;
endpackage

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
  parameter int unsigned WORD_W = ser_tx_pkg::DEF_WORD_W
) (
  input  logic              clk_byte,
  input  logic              rst,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] hold_q
);
  // Parallel word capture on the byte clock; idle pattern is all ones.
  always_ff @(posedge clk_byte) begin
    if (rst) hold_q <= '1;
    else     hold_q <= din;
  end
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift #(
  parameter int unsigned WORD_W     = ser_tx_pkg::DEF_WORD_W,
  parameter int unsigned LOAD_PHASE = ser_tx_pkg::DEF_LOAD_PHASE,
  localparam int unsigned CNT_W     = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk_bit,
  input  logic              rst,
  input  logic [WORD_W-1:0] hold_q,
  output logic              ser_bit,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              load_stb
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOAD_PHASE);

  logic [WORD_W-1:0] sreg;

  // Bit position inside the current byte period; zero at each byte edge
  // provided reset is released so that the first active bit edge is a byte edge.
  always_ff @(posedge clk_bit) begin
    if (rst)                   bit_cnt <= '0;
    else if (bit_cnt == CNT_LAST) bit_cnt <= '0;
    else                       bit_cnt <= bit_cnt + 1'b1;
  end

  assign load_stb = (bit_cnt == CNT_LOAD);

  // The holding register settled LOAD_PHASE bit periods earlier, so the copy
  // into the shifter never samples a word in transition.
  always_ff @(posedge clk_bit) begin
    if (rst)           sreg <= '1;
    else if (load_stb) sreg <= hold_q;
    else               sreg <= {1'b1, sreg[WORD_W-1:1]};
  end

  assign ser_bit = sreg[0];
endmodule

// File: rtl/ser_tx_steer.sv
module ser_tx_steer
  import ser_tx_pkg::*;
(
  input  logic clk_bit,
  input  logic rst,
  input  logic ser_bit,
  input  logic wrap_en,
  output logic line_out,
  output logic loop_out
);
  path_e path;
  assign path = wrap_en ? PATH_LOOP : PATH_LINE;

  // Registered steering: the unused output rests at a static one.
  always_ff @(posedge clk_bit) begin
    if (rst) begin
      line_out <= 1'b1;
      loop_out <= 1'b1;
    end else begin
      case (path)
        PATH_LOOP: begin
          line_out <= 1'b1;
          loop_out <= ser_bit;
        end
        default: begin
          line_out <= ser_bit;
          loop_out <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/ser_tx_wrap.sv
module ser_tx_wrap #(
  parameter int unsigned WORD_W     = ser_tx_pkg::DEF_WORD_W,
  parameter int unsigned LOAD_PHASE = ser_tx_pkg::DEF_LOAD_PHASE
) (
  input  logic              clk_byte,
  input  logic              clk_bit,
  input  logic              rst,
  input  logic [WORD_W-1:0] din,
  input  logic              wrap_en,
  output logic              line_out,
  output logic              loop_out
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [WORD_W-1:0] hold_q;
  logic              ser_bit;
  logic [CNT_W-1:0]  bit_cnt;
  logic              load_stb;

  ser_tx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk_byte (clk_byte),
    .rst      (rst),
    .din      (din),
    .hold_q   (hold_q)
  );

  ser_tx_shift #(.WORD_W(WORD_W), .LOAD_PHASE(LOAD_PHASE)) u_shift (
    .clk_bit  (clk_bit),
    .rst      (rst),
    .hold_q   (hold_q),
    .ser_bit  (ser_bit),
    .bit_cnt  (bit_cnt),
    .load_stb (load_stb)
  );

  ser_tx_steer u_steer (
    .clk_bit  (clk_bit),
    .rst      (rst),
    .ser_bit  (ser_bit),
    .wrap_en  (wrap_en),
    .line_out (line_out),
    .loop_out (loop_out)
  );
endmodule

// File: rtl/ser_tx_wrap_chk.sv
module ser_tx_wrap_chk #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned CNT_W  = 4
) (
  input logic             clk_bit,
  input logic             rst,
  input logic             wrap_en,
  input logic             ser_bit,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             load_stb,
  input logic             line_out,
  input logic             loop_out
);
  p_line_high_r5: assert property (@(posedge clk_bit) disable iff (rst)
    $past(wrap_en) |-> line_out);

  p_loop_mirror_r4: assert property (@(posedge clk_bit) disable iff (rst)
    $past(wrap_en) |-> (loop_out == $past(ser_bit)));

  p_loop_high_r6: assert property (@(posedge clk_bit) disable iff (rst)
    !$past(wrap_en) |-> loop_out);

  p_line_mirror_r3: assert property (@(posedge clk_bit) disable iff (rst)
    !$past(wrap_en) |-> (line_out == $past(ser_bit)));

  p_cnt_wrap_r2: assert property (@(posedge clk_bit) disable iff (rst)
    (bit_cnt == CNT_W'(WORD_W - 1)) |=> (bit_cnt == '0));

  p_load_spacing_r2: assert property (@(posedge clk_bit) disable iff (rst)
    load_stb |=> !load_stb);

  p_rst_idle_r8: assert property (@(posedge clk_bit)
    $past(rst) |-> (line_out && loop_out));
endmodule

bind ser_tx_wrap ser_tx_wrap_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk_bit  (clk_bit),
  .rst      (rst),
  .wrap_en  (wrap_en),
  .ser_bit  (ser_bit),
  .bit_cnt  (bit_cnt),
  .load_stb (load_stb),
  .line_out (line_out),
  .loop_out (loop_out)
);

// File: tb/ser_tx_wrap_bench.sv
module ser_tx_wrap_bench;
  localparam int W  = 10;
  localparam int LP = 3;
  localparam int NV = 8;
  localparam int KMAX = 10 * NV + LP + 5;

  // {wrap, word}
  localparam logic [10:0] VECS [0:NV-1] = '{
    {1'b0, 10'h17C}, {1'b0, 10'h283}, {1'b1, 10'h3FF}, {1'b1, 10'h000},
    {1'b0, 10'h155}, {1'b1, 10'h2AA}, {1'b0, 10'h001}, {1'b0, 10'h200}
  };

  logic clk_bit = 1'b0;
  logic clk_byte = 1'b0;
  int   ph = 0;
  logic rst = 1'b1;
  logic [W-1:0] din = '1;
  logic wrap_en = 1'b0;
  logic line_out, loop_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  ser_tx_wrap #(.WORD_W(W), .LOAD_PHASE(LP)) u_ser_tx_wrap (
    .clk_byte (clk_byte),
    .clk_bit  (clk_bit),
    .rst      (rst),
    .din      (din),
    .wrap_en  (wrap_en),
    .line_out (line_out),
    .loop_out (loop_out)
  );

  // 100 MHz bit clock; byte clock at one tenth, rising with the bit clock.
  always begin
    #5;
    clk_bit = 1'b1;
    if (ph == 0) clk_byte = 1'b1;
    if (ph == 5) clk_byte = 1'b0;
    ph = (ph == 9) ? 0 : ph + 1;
    #5;
    clk_bit = 1'b0;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    logic s, wk;
    int j;
    @(posedge clk_byte);
    repeat (9) @(posedge clk_bit);
    @(negedge clk_bit);
    chk("R8 line in reset", line_out, 1'b1);
    chk("R8 loop in reset", loop_out, 1'b1);
    rst = 1'b0;
    din = VECS[0][W-1:0];
    wrap_en = VECS[0][W];

    for (int k = 0; k <= KMAX; k++) begin
      @(posedge clk_bit);
      @(negedge clk_bit);
      wk = (k / 10 < NV) ? VECS[k / 10][W] : 1'b0;
      if (k < LP + 1) s = 1'b1;
      else begin
        j = k - LP - 1;
        s = (j / 10 < NV) ? VECS[j / 10][j % 10] : 1'b1;
      end
      if (k == LP)     chk("R7 before first bit", line_out, 1'b1);
      if (k == LP + 1) chk("R7 first bit timing", line_out, VECS[0][0]);
      if (wk) begin
        chk("R5 line static in wrap", line_out, 1'b1);
        chk("R4 loop carries stream (R1,R2)", loop_out, s);
      end else begin
        chk("R3 line lsb-first stream (R1,R2)", line_out, s);
        chk("R6 loop static without wrap", loop_out, 1'b1);
      end
      // inputs for the next edge
      if ((k + 1) % 10 == 0) begin
        din     = ((k + 1) / 10 < NV) ? VECS[(k + 1) / 10][W-1:0] : '1;
        wrap_en = ((k + 1) / 10 < NV) ? VECS[(k + 1) / 10][W] : 1'b0;
      end else if ((k + 1) % 10 == 1 && (k + 1) / 10 < NV) begin
        din = ~VECS[(k + 1) / 10][W-1:0]; // R1: garbage after capture
      end
    end

    // R9: reset in the middle of a zero word
    while (ph != 0) @(negedge clk_bit);
    din = '0;
    wrap_en = 1'b0;
    repeat (LP + 3) @(posedge clk_bit);
    @(negedge clk_bit);
    chk("R3 zero word on line", line_out, 1'b0);
    rst = 1'b1;
    @(posedge clk_bit);
    @(negedge clk_bit);
    chk("R9 line after mid-word reset", line_out, 1'b1);
    chk("R9 loop after mid-word reset", loop_out, 1'b1);
    wrap_en = 1'b1;
    @(posedge clk_bit);
    @(negedge clk_bit);
    chk("R8 line held in reset", line_out, 1'b1);
    chk("R8 loop held in reset", loop_out, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule